// File: doc/BRIEF.md
# Iterative Half-Adder Recursive Adder

This block adds two unsigned operands using only one half-adder per bit and a two-input selector in front of it, instead of a full-adder carry ripple. In the loading phase the selectors pass the external operands, so every bit forms its raw sum and generate carry. In the iterating phase the selectors pass the stored sum of the same bit and the stored carry from the bit below. These are fed back through the same half-adders on every clock until no carry is left in flight.

The phase is chosen by a single select input. The caller holds it low for at least one clock to capture the operands, then raises it and keeps it high. The done flag rises when the internal carry vector is all zero. The number of clocks depends on the data: it follows the longest carry chain in the operands, not the word width. A carry that leaves the top bit is caught in a sticky carry-out register and removed from the internal vector. The result and the flag stay held until select is lowered for the next addition.

Top module: `hia_iter_adder`

## Requirements
- R1: While rst_ni is low and after it is released, sum_o, cout_o and done_o are all 0 until the first clock edge with a load.
- R2: On each rising clock edge with sel_i = 0, sum_o becomes a_i XOR b_i. The pending carry into bit i+1 becomes a_i[i] AND b_i[i], and cout_o becomes a_i[WIDTH-1] AND b_i[WIDTH-1].
- R3: On each rising edge with sel_i = 1, every sum bit becomes its old value XOR the pending carry into that bit. The carry into bit i+1 becomes old sum bit i AND old carry into bit i. So after the first iterating edge, sum_o equals (a XOR b) XOR ((a AND b) shifted up one place), truncated to WIDTH bits.
- R4: When done_o is high, {cout_o, sum_o} equals a_i + b_i for the operands that were loaded.
- R5: done_o first rises after max(1, D) rising edges with sel_i = 1. D is the largest chain length over all generate bits i < WIDTH-1, where a_i[i] = b_i[i] = 1. The chain length of such a bit is j - i, with j the first bit above i where a_i[j] XOR b_i[j] = 0, or WIDTH-1-i if there is no such bit. A generate bit at the top contributes 0.
- R6: done_o is 0 whenever sel_i is 0, and it only rises one edge or more after sel_i was sampled high.
- R7: Once done_o is high and sel_i stays 1, done_o, sum_o and cout_o keep their values.
- R8: A sum bit and the pending carry out of that same bit are never both 1.
- R9: During iteration the number of pending carries never grows, and once cout_o is 1 it stays 1 until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | 0 loads operands, 1 iterates on fed-back sums and carries |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| sum_o | output | WIDTH | Current sum bits, final result once done |
| cout_o | output | 1 | Sticky carry out of the top bit |
| done_o | output | 1 | High when no carry remains and select is high |

## Verification
Operands with no generate bit (F7F7 + 0000) show that completion takes a single iterating edge. Two short chains ended by a kill bit (F7F7 + 0101) check that parallel chains finish together after three edges. FFFF + 0101 mixes an absorbed chain with one that leaves the top bit. FFFF + 0001 is the longest possible chain, and 8000 + 8000 produces a top-bit generate that sets the carry-out with no iteration at all. Random operands then compare the sum, the carry-out and the exact completion cycle against the chain-length formula. Hold cycles after completion check that the result stays fixed.

// File: rtl/hia_pkg.sv
package hia_pkg;
  typedef enum logic {
    PH_LOAD = 1'b0,
    PH_ITER = 1'b1
  } phase_e;
endpackage

// File: rtl/hia_bit_cell.sv
module hia_bit_cell (
  input  logic load_i,
  input  logic a_i,
  input  logic b_i,
  input  logic s_prev_i,
  input  logic c_prev_i,
  output logic s_o,
  output logic g_o
);
  logic x, y;
  // per-bit selector: operands on load, feedback otherwise
  assign x   = load_i ? a_i : s_prev_i;
  assign y   = load_i ? b_i : c_prev_i;
  assign s_o = x ^ y;
  assign g_o = x & y;
endmodule

// File: rtl/hia_done_detect.sv
module hia_done_detect #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] carry_i,
  input  logic             sel_i,
  input  logic             iter_i,
  output logic             done_o
);
  assign done_o = sel_i & iter_i & ~(|carry_i);
endmodule

// File: rtl/hia_iter_adder.sv
module hia_iter_adder
  import hia_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             done_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] s_q, c_q, s_d, g_d, c_d;
  logic             cout_q, cout_d, load;
  phase_e           ph_q;

  assign load = ~sel_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    hia_bit_cell u_cell (
      .load_i  (load),
      .a_i     (a_i[i]),
      .b_i     (b_i[i]),
      .s_prev_i(s_q[i]),
      .c_prev_i(c_q[i]),
      .s_o     (s_d[i]),
      .g_o     (g_d[i])
    );
  end

  // c_q[i] = carry pending into bit i; top carry leaves into cout
  assign c_d    = {g_d[MSB-1:0], 1'b0};
  assign cout_d = load ? g_d[MSB] : (cout_q | g_d[MSB]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q    <= '0;
      c_q    <= '0;
      cout_q <= 1'b0;
      ph_q   <= PH_LOAD;
    end else begin
      s_q    <= s_d;
      c_q    <= c_d;
      cout_q <= cout_d;
      ph_q   <= sel_i ? PH_ITER : PH_LOAD;
    end
  end

  hia_done_detect #(.WIDTH(WIDTH)) u_done (
    .carry_i(c_q),
    .sel_i  (sel_i),
    .iter_i (ph_q == PH_ITER),
    .done_o (done_o)
  );

  assign sum_o  = s_q;
  assign cout_o = cout_q;
endmodule

// File: rtl/hia_iter_adder_chk.sv
module hia_iter_adder_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic             done_o,
  input logic [WIDTH-1:0] carry_q
);
  p_no_pair11_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_o[WIDTH-2:0] & carry_q[WIDTH-1:1]) == '0);

  p_done_after_iter_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(sel_i));

  p_done_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(done_o) && $past(sel_i) && sel_i) |->
      (done_o && $stable(sum_o) && $stable(cout_o)));

  p_carry_shrinks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sel_i) |-> ($countones(carry_q) <= $past($countones(carry_q))));

  p_cout_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sel_i) && $past(cout_o)) |-> cout_o);
endmodule

bind hia_iter_adder hia_iter_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sel_i  (sel_i),
  .sum_o  (sum_o),
  .cout_o (cout_o),
  .done_o (done_o),
  .carry_q(c_q)
);

// File: tb/hia_iter_adder_tb.sv
module hia_iter_adder_tb;
  localparam int W = 16;
  localparam logic [W-1:0] MASK = '1;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         sel_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [W-1:0] sum_o;
  logic         cout_o, done_o;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  hia_iter_adder #(.WIDTH(W)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int chain_len(input logic [W-1:0] a, input logic [W-1:0] b);
    int d = 0;
    for (int i = 0; i < W - 1; i++) begin
      if (a[i] & b[i]) begin
        int j = i + 1;
        int len;
        while (j < W && (a[j] ^ b[j])) j++;
        len = (j < W) ? (j - i) : (W - 1 - i);
        if (len > d) d = len;
      end
    end
    return d;
  endfunction

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b);
    int d = chain_len(a, b);
    int need = (d < 1) ? 1 : d;
    logic [W:0] total = {1'b0, a} + {1'b0, b};
    logic [W-1:0] first = (a ^ b) ^ (((a & b) << 1) & MASK);
    logic [W:0] held;
    a_i = a; b_i = b; sel_i = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    chk(sum_o == (a ^ b), "R2 load sum", {1'b0, sum_o}, {1'b0, a ^ b});
    chk(cout_o == (a[W-1] & b[W-1]), "R2 load cout", {{W{1'b0}}, cout_o}, {{W{1'b0}}, a[W-1] & b[W-1]});
    chk(done_o == 1'b0, "R6 done low on load", {{W{1'b0}}, done_o}, '0);
    sel_i = 1'b1;
    for (int n = 1; n <= need; n++) begin
      @(posedge clk_i); @(negedge clk_i);
      if (n == 1)
        chk(sum_o == first, "R3 first iteration", {1'b0, sum_o}, {1'b0, first});
      chk(done_o == (n == need), "R5 completion cycle", {{W{1'b0}}, done_o},
          {{W{1'b0}}, 1'(n == need)});
    end
    chk({cout_o, sum_o} == total, "R4 result", {cout_o, sum_o}, total);
    held = {cout_o, sum_o};
    for (int h = 0; h < 2; h++) begin
      @(posedge clk_i); @(negedge clk_i);
      chk(done_o && {cout_o, sum_o} == held, "R7 hold", {cout_o, sum_o}, held);
    end
    sel_i = 1'b0;
    #1;
    chk(done_o == 1'b0, "R6 done gated by sel", {{W{1'b0}}, done_o}, '0);
  endtask

  initial begin
    #1;
    chk({cout_o, sum_o} == '0 && !done_o, "R1 in reset", {cout_o, sum_o}, '0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({cout_o, sum_o} == '0 && !done_o, "R1 after release", {cout_o, sum_o}, '0);
    run_op(16'hF7F7, 16'h0000);
    run_op(16'hF7F7, 16'h0101);
    run_op(16'hFFFF, 16'h0101);
    run_op(16'hFFFF, 16'h0001);
    run_op(16'h8000, 16'h8000);
    run_op(16'h0000, 16'h0000);
    run_op(16'hFFFF, 16'hFFFF);
    for (int k = 0; k < 40; k++) run_op(W'($urandom), W'($urandom));
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule